// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register storage of a 32-bit processor core in which the physical register behind a given 4-bit index depends on the current privilege mode. The core presents a 5-bit mode code together with two read indices and one write index. The block resolves each index to the copy owned by that mode. Registers 0 to 7 and the program counter at index 15 are common to every mode. The fast-interrupt mode owns private copies of indices 8 to 14. The other four exception modes own private copies of only the stack pointer (13) and the link register (14).

Each exception mode also owns one saved status word. It is read and written through a dedicated port that always follows the live mode. A bank-override input lets read port A and the write port reach the bank of a different mode without a mode switch. Exception handlers use this to save or restore the user-mode stack pointer and link register.

Reads are combinational. Writes take effect on the rising clock edge. The program counter is held as an ordinary register, and the fetch, increment and flag logic lie outside the block.

Top module: `banked_regfile`

## Requirements
- R1: Mode codes are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. Any other 5-bit value selects the User bank.
- R2: Indices 0 to 7 reach the same storage in every mode.
- R3: In FIQ mode, indices 8 to 14 reach storage that no other mode can reach, so writes there leave the User values of those indices unchanged.
- R4: IRQ, Supervisor, Abort and Undefined modes each have a private index 13 and index 14. Their indices 8 to 12 reach the User copies.
- R5: System mode reaches exactly the same registers as User mode at every index.
- R6: Index 15 (the program counter) is a single register shared by all modes.
- R7: Each of the five exception modes has its own saved status word, addressed by `mode_i`. In User or System mode the saved status read returns zero and a saved status write is discarded.
- R8: While `ovr_en_i` is 1, read port A and the write port use the bank of `ovr_mode_i`. Read port B and the saved status port keep using `mode_i`.
- R9: A write lands on the rising clock edge. A read of the same register in the same cycle returns the value from before the write, and the new value is visible in the next cycle.
- R10: While `rst_n` is 0, all general registers and saved status words are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode code |
| ovr_en_i | input | 1 | Route read port A and the write port to the bank of `ovr_mode_i` |
| ovr_mode_i | input | 5 | Mode whose bank is used while the override is on |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data (combinational) |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data (combinational) |
| wr_en_i | input | 1 | Write enable for the general register write port |
| wr_idx_i | input | 4 | Write port register index |
| wr_data_i | input | 32 | Write port data |
| sav_wr_en_i | input | 1 | Saved status write enable |
| sav_wr_data_i | input | 32 | Saved status write data |
| sav_rd_data_o | output | 32 | Saved status read data for the current mode |

## Verification
The hardest situation to reach from the ports is one in which two banks hold different values at the same index and the wrong copy would still look plausible. An example is a FIQ write to index 10 that must leave the User copy untouched, or an override write from Supervisor mode that must land in the User link register and not the Supervisor one. The directed part of the stimulus fills each bank with values unique to its owner. It then reads the same index from every other mode and through the override, so that any aliasing shows up as a wrong value. A long random phase follows, biased toward indices 8 to 14 and including an illegal mode code. It is compared on every clock against a behavioural model that keys storage by owner and index.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int MODE_W = 5;
    localparam int IDX_W  = 4;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    // bank owners; the order places the user bank at zero and the saved-status
    // slot of an exception bank at its value minus one
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int N_BANKS   = 6;
    localparam int N_SAVED   = N_BANKS - 1;

    // logical index layout
    localparam int SHARED_LO = 8;     // indices below this are never banked
    localparam int SP_IDX    = 13;
    localparam int LR_IDX    = 14;
    localparam int PC_IDX    = 15;
    localparam int MID_CNT   = SP_IDX - SHARED_LO;   // indices only FIQ banks
    localparam int PER_BANK  = PC_IDX - SP_IDX;      // sp and lr per bank

    // flat physical layout
    localparam int USR_MID_BASE = SHARED_LO;
    localparam int FIQ_MID_BASE = USR_MID_BASE + MID_CNT;
    localparam int STK_BASE     = FIQ_MID_BASE + MID_CNT;
    localparam int PC_SLOT      = STK_BASE + N_BANKS * PER_BANK;
    localparam int PHYS_CNT     = PC_SLOT + 1;
    localparam int PHYS_W       = $clog2(PHYS_CNT);
    localparam int SLOT_W       = $clog2(N_SAVED);

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              has_saved
);

    always_comb begin
        case (mode)
            MODE_FIQ: bank = BK_FIQ;
            MODE_IRQ: bank = BK_IRQ;
            MODE_SVC: bank = BK_SVC;
            MODE_ABT: bank = BK_ABT;
            MODE_UND: bank = BK_UND;
            MODE_USR: bank = BK_USR;
            MODE_SYS: bank = BK_USR;
            default:  bank = BK_USR;
        endcase
        has_saved = (bank != BK_USR);
    end

endmodule

// File: rtl/rf_index_map.sv
module rf_index_map
    import rf_pkg::*;
(
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] phys
);

    int i_v;
    int b_v;
    int slot_v;

    always_comb begin
        i_v = int'(idx);
        b_v = int'(bank);
        if (i_v < SHARED_LO) begin
            slot_v = i_v;
        end else if (i_v == PC_IDX) begin
            slot_v = PC_SLOT;
        end else if (i_v >= SP_IDX) begin
            slot_v = STK_BASE + b_v * PER_BANK + (i_v - SP_IDX);
        end else if (bank == BK_FIQ) begin
            slot_v = FIQ_MID_BASE + (i_v - SHARED_LO);
        end else begin
            slot_v = USR_MID_BASE + (i_v - SHARED_LO);
        end
        phys = PHYS_W'(slot_v);
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              ovr_en_i,
    input  logic [MODE_W-1:0] ovr_mode_i,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sav_wr_en_i,
    input  logic [SR_W-1:0]   sav_wr_data_i,
    output logic [SR_W-1:0]   sav_rd_data_o
);

    // mode sources: 0 = live mode, 1 = mode after override
    localparam int N_SRC  = 2;
    // ports: 0 = read A, 1 = read B, 2 = write
    localparam int N_PORT = 3;
    localparam logic [N_PORT-1:0] PORT_ALT = 3'b101;
    localparam int P_RDA = 0;
    localparam int P_RDB = 1;
    localparam int P_WR  = 2;

    logic [MODE_W-1:0] src_mode  [N_SRC];
    bank_e             src_bank  [N_SRC];
    logic              src_saved [N_SRC];

    assign src_mode[0] = mode_i;
    assign src_mode[1] = ovr_en_i ? ovr_mode_i : mode_i;

    for (genvar g = 0; g < N_SRC; g++) begin : g_dec
        rf_mode_decode u_dec (
            .mode      (src_mode[g]),
            .bank      (src_bank[g]),
            .has_saved (src_saved[g])
        );
    end

    logic [IDX_W-1:0]  port_idx  [N_PORT];
    logic [PHYS_W-1:0] port_phys [N_PORT];

    assign port_idx[P_RDA] = rd_a_idx_i;
    assign port_idx[P_RDB] = rd_b_idx_i;
    assign port_idx[P_WR]  = wr_idx_i;

    for (genvar p = 0; p < N_PORT; p++) begin : g_map
        localparam int SRC = PORT_ALT[p] ? 1 : 0;
        rf_index_map u_map (
            .bank (src_bank[SRC]),
            .idx  (port_idx[p]),
            .phys (port_phys[p])
        );
    end

    typedef struct {
        logic [DATA_W-1:0] gpr [PHYS_CNT];
        logic [SR_W-1:0]   sav [N_SAVED];
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [SLOT_W-1:0] sav_slot;

    always_comb begin
        sav_slot = src_saved[0] ? SLOT_W'(int'(src_bank[0]) - 1) : '0;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.gpr[port_phys[P_WR]] = wr_data_i;
        end
        if (sav_wr_en_i && src_saved[0]) begin
            st_d.sav[sav_slot] = sav_wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_CNT; i++) st_q.gpr[i] <= '0;
            for (int j = 0; j < N_SAVED; j++)  st_q.sav[j] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_data_o   = st_q.gpr[port_phys[P_RDA]];
    assign rd_b_data_o   = st_q.gpr[port_phys[P_RDB]];
    assign sav_rd_data_o = src_saved[0] ? st_q.sav[sav_slot] : '0;

endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SR_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic              ovr_en_i,
    input logic [MODE_W-1:0] ovr_mode_i,
    input logic [IDX_W-1:0]  rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [IDX_W-1:0]  rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [SR_W-1:0]   sav_rd_data_o
);

    // R6: both read ports at index 15 see one register whatever the override
    a_r6_pc_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_a_idx_i) == PC_IDX && int'(rd_b_idx_i) == PC_IDX)
            |-> (rd_a_data_o == rd_b_data_o));

    // R2: low indices agree between the override port and the live port
    a_r2_low_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == rd_b_idx_i && int'(rd_a_idx_i) < SHARED_LO)
            |-> (rd_a_data_o == rd_b_data_o));

    // R5: System on port B equals User on port A at every index
    a_r5_system_is_user: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SYS && ovr_en_i && ovr_mode_i == MODE_USR
         && rd_a_idx_i == rd_b_idx_i)
            |-> (rd_a_data_o == rd_b_data_o));

    // R7: no saved status visible in User or System mode
    a_r7_no_saved_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_USR || mode_i == MODE_SYS) |-> (sav_rd_data_o == '0));

    // R9: a write without override is seen on port B the next cycle
    a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && !$past(ovr_en_i)
         && $past(mode_i) == mode_i && rd_b_idx_i == $past(wr_idx_i))
            |-> (rd_b_data_o == $past(wr_data_i)));

    // R10: storage reads zero when reset is released
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_a_data_o == '0 && rd_b_data_o == '0
                          && sav_rd_data_o == '0));

endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W), .SR_W(SR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .ovr_en_i      (ovr_en_i),
    .ovr_mode_i    (ovr_mode_i),
    .rd_a_idx_i    (rd_a_idx_i),
    .rd_a_data_o   (rd_a_data_o),
    .rd_b_idx_i    (rd_b_idx_i),
    .rd_b_data_o   (rd_b_data_o),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_idx_i),
    .wr_data_i     (wr_data_i),
    .sav_rd_data_o (sav_rd_data_o)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10000;
    logic        ovr_en_i = 1'b0;
    logic [4:0]  ovr_mode_i = 5'b10000;
    logic [3:0]  rd_a_idx_i = '0;
    logic [31:0] rd_a_data_o;
    logic [3:0]  rd_b_idx_i = '0;
    logic [31:0] rd_b_data_o;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        sav_wr_en_i = 1'b0;
    logic [31:0] sav_wr_data_i = '0;
    logic [31:0] sav_rd_data_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    banked_regfile uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .ovr_en_i      (ovr_en_i),
        .ovr_mode_i    (ovr_mode_i),
        .rd_a_idx_i    (rd_a_idx_i),
        .rd_a_data_o   (rd_a_data_o),
        .rd_b_idx_i    (rd_b_idx_i),
        .rd_b_data_o   (rd_b_data_o),
        .wr_en_i       (wr_en_i),
        .wr_idx_i      (wr_idx_i),
        .wr_data_i     (wr_data_i),
        .sav_wr_en_i   (sav_wr_en_i),
        .sav_wr_data_i (sav_wr_data_i),
        .sav_rd_data_o (sav_rd_data_o)
    );

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111, BADM = 5'b00101;

    // behavioural model: storage keyed by owner and index, absent means zero
    logic [31:0] gmem [int];
    logic [31:0] smem [int];

    function automatic int owner(input logic [4:0] m);
        case (m)
            FIQ: return 1;
            IRQ: return 2;
            SVC: return 3;
            ABT: return 4;
            UND: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int key(input logic [4:0] m, input int idx);
        int o = owner(m);
        if (idx < 8 || idx == 15) return idx;
        if (o == 1) return 100 + idx;
        if (o >= 2 && idx >= 13) return o * 100 + idx;
        return idx;
    endfunction

    function automatic logic [31:0] gread(input int k);
        return gmem.exists(k) ? gmem[k] : 32'h0;
    endfunction

    function automatic logic [31:0] sread(input int o);
        if (o == 0) return 32'h0;
        return smem.exists(o) ? smem[o] : 32'h0;
    endfunction

    function automatic string tagof(input logic [4:0] m, input int idx, input bit ovr);
        if (idx < 8) return "R2";
        if (idx == 15) return "R6";
        if (ovr) return "R8";
        if (m == SYS) return "R5";
        if (owner(m) == 1) return "R3";
        if (owner(m) >= 2) return "R4";
        if (m != USR) return "R1";
        return "R9";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // called just after a negedge with inputs set; checks, then commits at posedge
    task automatic step(input string tag);
        logic [4:0] eff;
        string ta, tbn, ts;
        #1;
        eff = ovr_en_i ? ovr_mode_i : mode_i;
        ta  = (tag != "") ? tag : tagof(eff, int'(rd_a_idx_i), ovr_en_i);
        tbn = (tag != "") ? tag : tagof(mode_i, int'(rd_b_idx_i), 1'b0);
        ts  = (tag != "") ? tag : "R7";
        check(ta,  "port A", rd_a_data_o, gread(key(eff, int'(rd_a_idx_i))));
        check(tbn, "port B", rd_b_data_o, gread(key(mode_i, int'(rd_b_idx_i))));
        check(ts,  "saved",  sav_rd_data_o, sread(owner(mode_i)));
        @(posedge clk);
        if (wr_en_i) gmem[key(eff, int'(wr_idx_i))] = wr_data_i;
        if (sav_wr_en_i && owner(mode_i) != 0) smem[owner(mode_i)] = sav_wr_data_i;
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en_i = 1'b0;
        sav_wr_en_i = 1'b0;
        ovr_en_i = 1'b0;
    endtask

    task automatic wr(input logic [4:0] m, input int idx, input logic [31:0] d);
        quiet();
        mode_i = m;
        wr_en_i = 1'b1;
        wr_idx_i = 4'(idx);
        wr_data_i = d;
        rd_a_idx_i = 4'(idx);
        rd_b_idx_i = 4'(idx);
    endtask

    task automatic rd(input logic [4:0] m, input int ia, input int ib);
        quiet();
        mode_i = m;
        rd_a_idx_i = 4'(ia);
        rd_b_idx_i = 4'(ib);
    endtask

    function automatic logic [4:0] pick(input int n);
        case (n)
            0: return USR; 1: return FIQ; 2: return IRQ; 3: return SVC;
            4: return ABT; 5: return UND; 6: return SYS; default: return BADM;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: every index reads zero after reset, in two banks
        for (int i = 0; i < 16; i++) begin rd(USR, i, 15 - i); step("R10"); end
        for (int i = 8; i < 15; i++) begin rd(FIQ, i, i); step("R10"); end

        // R9: fill the user bank; same-cycle reads return the old value
        for (int i = 0; i < 16; i++) begin wr(USR, i, 32'h1000_0000 + i); step("R9"); end

        // R3: FIQ private 8..14, then user copies unchanged
        for (int i = 8; i < 15; i++) begin wr(FIQ, i, 32'hF100_0000 + i); step("R3"); end
        for (int i = 8; i < 15; i++) begin rd(FIQ, i, i); step("R3"); end
        for (int i = 8; i < 15; i++) begin rd(USR, i, i); step("R3"); end
        // R2: low registers shared with FIQ
        for (int i = 0; i < 8; i++) begin rd(FIQ, i, 7 - i); step("R2"); end

        // R4: each other exception mode gets its own sp and lr only
        for (int m = 2; m < 6; m++) begin
            wr(pick(m), 13, 32'h5000_0000 + m); step("R4");
            wr(pick(m), 14, 32'h6000_0000 + m); step("R4");
        end
        for (int m = 2; m < 6; m++) begin
            rd(pick(m), 13, 14); step("R4");
            rd(pick(m), 12, 8);  step("R4");
        end
        rd(USR, 13, 14); step("R4");

        // R5: system sees the user bank
        for (int i = 8; i < 16; i++) begin rd(SYS, i, i); step("R5"); end
        wr(SYS, 13, 32'h7777_0013); step("R5");
        rd(USR, 13, 13); step("R5");

        // R6: program counter from every mode
        wr(UND, 15, 32'hC0DE_0015); step("R6");
        for (int m = 0; m < 8; m++) begin rd(pick(m), 15, 15); step("R6"); end

        // R7: saved status per exception mode, none in user/system
        for (int m = 1; m < 6; m++) begin
            quiet(); mode_i = pick(m);
            sav_wr_en_i = 1'b1; sav_wr_data_i = 32'hA500_0000 + m; step("R7");
        end
        for (int m = 1; m < 6; m++) begin rd(pick(m), 0, 0); step("R7"); end
        quiet(); mode_i = SYS; sav_wr_en_i = 1'b1; sav_wr_data_i = 32'hDEAD_BEEF; step("R7");
        quiet(); mode_i = USR; sav_wr_en_i = 1'b1; sav_wr_data_i = 32'hBEEF_DEAD; step("R7");
        for (int m = 0; m < 8; m++) begin rd(pick(m), 1, 1); step("R7"); end

        // R1: an undefined mode code behaves as User
        rd(BADM, 13, 9); step("R1");
        wr(BADM, 14, 32'h0BAD_0014); step("R1");
        rd(USR, 14, 14); step("R1");

        // R8: override from supervisor into the user link register
        quiet(); mode_i = SVC; ovr_en_i = 1'b1; ovr_mode_i = USR;
        wr_en_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'h0E0E_0014;
        rd_a_idx_i = 4'd14; rd_b_idx_i = 4'd14; step("R8");
        quiet(); mode_i = SVC; ovr_en_i = 1'b1; ovr_mode_i = USR;
        rd_a_idx_i = 4'd14; rd_b_idx_i = 4'd14; step("R8");
        rd(USR, 14, 14); step("R8");
        rd(SVC, 14, 14); step("R8");
        quiet(); mode_i = USR; ovr_en_i = 1'b1; ovr_mode_i = FIQ;
        rd_a_idx_i = 4'd10; rd_b_idx_i = 4'd10; step("R8");

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            mode_i        = pick($urandom_range(0, 7));
            ovr_en_i      = ($urandom_range(0, 3) == 0);
            ovr_mode_i    = pick($urandom_range(0, 7));
            rd_a_idx_i    = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(8, 14))
                                                        : 4'($urandom_range(0, 15));
            rd_b_idx_i    = 4'($urandom_range(0, 15));
            wr_en_i       = $urandom_range(0, 1) == 1;
            wr_idx_i      = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(8, 14))
                                                        : rd_a_idx_i;
            wr_data_i     = $urandom;
            sav_wr_en_i   = ($urandom_range(0, 3) == 0);
            sav_wr_data_i = $urandom;
            step("");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule